// File: doc/BRIEF.md
# Low-Power Mode Sequencer for a Self-Refreshing Memory

This block decides which power state a self-refreshing memory is in: active, standby, partial-array refresh, deep power-down, or the initialization wait that follows deep power-down. It watches the chip enable and an active-low sleep pin, and it holds a small configuration register. That register contains a sleep-select bit, a refresh-size code and a region-anchor bit. From these it drives four things: the current mode, a flag that says whether reads and writes may proceed, a refresh-enable flag, and the inclusive address window that the refresh engine must keep alive.

The sleep pin must stay low for a qualifying number of clock cycles before a low-power mode begins. The sleep-select bit then chooses the mode. When it is set, the block enters partial refresh, which ends as soon as the pin rises. When it is clear, the block enters deep power-down. Refresh stops in that state and the contents are reported lost. Leaving deep power-down starts a fixed initialization wait.

A register write that sets the sleep-select bit behaves differently. It enters partial refresh at once, and from then until the next power-on reset the pin no longer starts any low-power mode. The pin is still needed to enable register writes. A register write can never lead to deep power-down.

Top module: `lpm_seq`

## Requirements
- R1: While `por_n` is low, and until the first mode change after it rises, the outputs are `mode`=STANDBY(1), `access_ok`=1, `refresh_en`=1, window 0 to 2^ADDR_W-1 and `data_lost`=0. The register resets to sleep-select 1, size code 0 and anchor 0.
- R2: In a normal mode, `mode` becomes STANDBY(1) at the next edge if `ce_n` and `sleep_n` are both high, and ACTIVE(0) otherwise. Both of these modes assert `access_ok`.
- R3: A low-power mode is entered from ACTIVE or STANDBY only at the edge where `sleep_n` is sampled low for the (QUAL_CYC+1)-th consecutive time. Any high sample restarts the count.
- R4: A pin-entered low-power mode with sleep-select 1 is PARTIAL(2). When `sleep_n` is sampled high in that mode and there is no lock, the next edge returns to a normal mode with `access_ok`=1.
- R5: A pin-entered low-power mode with sleep-select 0 is DEEP(3). It has `refresh_en`=0, with the window reported as 0..0. Entering DEEP sets `data_lost`, which stays set until `por_n`.
- R6: In DEEP, a high `sleep_n` moves the block to INIT(4) at the next edge. INIT lasts exactly INIT_CYC cycles and then gives way to a normal mode.
- R7: `access_ok` is 0 in PARTIAL, DEEP and INIT. Register writes are ignored in DEEP and INIT.
- R8: A register write is accepted at an edge where `cfg_we`=1, `sleep_n`=0 and the mode is ACTIVE, STANDBY or PARTIAL. If it sets sleep-select to 1, the next mode is PARTIAL. A lock is also set until `por_n`: under the lock the pin starts no low-power mode and never ends PARTIAL, and only a write with sleep-select 0 leaves it.
- R9: An accepted write with sleep-select 0 goes to a normal mode, never to DEEP.
- R10: In PARTIAL, size code 0 keeps the whole array, 1 keeps half, 2 keeps a quarter and 3 keeps an eighth. Codes 4 to 7 keep nothing, and `refresh_en` is then 0 with the window 0..0. Anchor 0 places the region at address 0 and anchor 1 ends it at 2^ADDR_W-1. In every mode other than PARTIAL and DEEP, the window is the full array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ce_n | input | 1 | Chip enable, active low |
| sleep_n | input | 1 | Sleep pin, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sleep | input | 1 | Sleep-select bit to write |
| cfg_top | input | 1 | Region anchor to write (1 = top of map) |
| cfg_part | input | 3 | Refresh-size code to write |
| mode | output | 3 | Current mode: 0 ACTIVE, 1 STANDBY, 2 PARTIAL, 3 DEEP, 4 INIT |
| access_ok | output | 1 | Reads and writes may proceed |
| refresh_en | output | 1 | Refresh engine enabled |
| ref_lo | output | ADDR_W | First address to refresh |
| ref_hi | output | ADDR_W | Last address to refresh |
| data_lost | output | 1 | Unrefreshed contents were lost in deep power-down |

## Verification
The bench builds the block with ADDR_W=8, QUAL_CYC=5 and INIT_CYC=12. With these values, a pin low that falls one cycle short of qualifying and a low that qualifies exactly can each be produced in a handful of cycles. The full INIT wait fits in the run several times over. The 256-word map makes every top- and bottom-anchored window an exact small number that can be checked.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

  typedef enum logic [2:0] {
    M_ACTIVE  = 3'd0,
    M_STANDBY = 3'd1,
    M_PAR     = 3'd2,
    M_DPD     = 3'd3,
    M_INIT    = 3'd4
  } lpm_mode_e;

  typedef struct packed {
    logic       sleep;
    logic       top;
    logic [2:0] part;
  } lpm_cfg_t;

  localparam lpm_cfg_t CFG_RST = '{sleep: 1'b1, top: 1'b0, part: 3'd0};

  // Codes 4..7 keep no region at all.
  function automatic logic part_is_none(input logic [2:0] part);
    return part[2];
  endfunction

  // Number of words kept alive: the array size shifted down by the code.
  function automatic logic [32:0] span_words(input logic [2:0] part, input int unsigned aw);
    logic [32:0] full;
    full = 33'd1 << aw;
    return full >> part[1:0];
  endfunction

  // First kept address: zero for a bottom anchor, array end minus span for a top anchor.
  function automatic logic [32:0] region_base(input logic [2:0] part, input logic top,
                                              input int unsigned aw);
    logic [32:0] full;
    full = 33'd1 << aw;
    return top ? (full - span_words(part, aw)) : 33'd0;
  endfunction

  function automatic logic mode_allows_access(input lpm_mode_e m);
    return (m == M_ACTIVE) || (m == M_STANDBY);
  endfunction

  function automatic logic mode_takes_cfg(input lpm_mode_e m);
    return (m == M_ACTIVE) || (m == M_STANDBY) || (m == M_PAR);
  endfunction

endpackage

// File: rtl/lpm_qual.sv
`timescale 1ns/1ps
module lpm_qual #(
  parameter int QUAL_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic hit
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(QUAL_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              low_cnt <= '0;
    else if (pin_n)          low_cnt <= '0;
    else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
  end

  // Qualified when the pin has already been low QUAL_CYC samples and is still low.
  assign hit = (low_cnt == LIM) && !pin_n;
endmodule

// File: rtl/lpm_init_tmr.sv
`timescale 1ns/1ps
module lpm_init_tmr #(
  parameter int INIT_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INIT_CYC - 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)      wait_cnt <= '0;
    else if (wait_cnt != LAST) wait_cnt <= wait_cnt + 1'b1;
  end

  assign done = run && (wait_cnt == LAST);
endmodule

// File: rtl/lpm_range.sv
`timescale 1ns/1ps
module lpm_range
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  lpm_mode_e          mode_q,
  input  lpm_cfg_t           cfg_q,
  output logic               en,
  output logic [ADDR_W-1:0]  lo,
  output logic [ADDR_W-1:0]  hi
);
  localparam int unsigned AWU = ADDR_W;

  logic [32:0] base_w;
  logic [32:0] last_w;

  always_comb begin
    base_w = region_base(cfg_q.part, cfg_q.top, AWU);
    last_w = base_w + span_words(cfg_q.part, AWU) - 33'd1;
    en = 1'b1;
    lo = '0;
    hi = '1;
    if (mode_q == M_DPD || (mode_q == M_PAR && part_is_none(cfg_q.part))) begin
      en = 1'b0;
      hi = '0;
    end else if (mode_q == M_PAR) begin
      lo = ADDR_W'(base_w);
      hi = ADDR_W'(last_w);
    end
  end
endmodule

// File: rtl/lpm_seq.sv
`timescale 1ns/1ps
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int QUAL_CYC = 1000,
  parameter int INIT_CYC = 15000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ce_n,
  input  logic              sleep_n,
  input  logic              cfg_we,
  input  logic              cfg_sleep,
  input  logic              cfg_top,
  input  logic [2:0]        cfg_part,
  output logic [2:0]        mode,
  output logic              access_ok,
  output logic              refresh_en,
  output logic [ADDR_W-1:0] ref_lo,
  output logic [ADDR_W-1:0] ref_hi,
  output logic              data_lost
);
  lpm_mode_e mode_q, mode_d;
  lpm_cfg_t  cfg_q;
  logic      sw_lock;
  logic      lost_q;

  // Named internal events
  logic      qual_hit;
  logic      init_done;
  logic      cfg_acc;
  logic      pin_entry;
  logic      enter_dpd;
  lpm_mode_e normal_mode;

  lpm_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(por_n), .pin_n(sleep_n), .hit(qual_hit)
  );

  lpm_init_tmr #(.INIT_CYC(INIT_CYC)) u_tmr (
    .clk(clk), .rst_n(por_n), .run(mode_q == M_INIT), .done(init_done)
  );

  lpm_range #(.ADDR_W(ADDR_W)) u_rng (
    .mode_q(mode_q), .cfg_q(cfg_q), .en(refresh_en), .lo(ref_lo), .hi(ref_hi)
  );

  assign cfg_acc     = cfg_we && !sleep_n && mode_takes_cfg(mode_q);
  assign pin_entry   = qual_hit && !sw_lock;
  assign normal_mode = (ce_n && sleep_n) ? M_STANDBY : M_ACTIVE;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_DPD:  if (sleep_n) mode_d = M_INIT;
      M_INIT: if (init_done) mode_d = normal_mode;
      M_PAR: begin
        if (cfg_acc)                mode_d = cfg_sleep ? M_PAR : normal_mode;
        else if (!sw_lock && sleep_n) mode_d = normal_mode;
      end
      default: begin
        if (cfg_acc)        mode_d = cfg_sleep ? M_PAR : normal_mode;
        else if (pin_entry) mode_d = cfg_q.sleep ? M_PAR : M_DPD;
        else                mode_d = normal_mode;
      end
    endcase
  end

  assign enter_dpd = (mode_d == M_DPD) && (mode_q != M_DPD);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      mode_q  <= M_STANDBY;
      cfg_q   <= CFG_RST;
      sw_lock <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (cfg_acc) begin
        cfg_q <= '{sleep: cfg_sleep, top: cfg_top, part: cfg_part};
        if (cfg_sleep) sw_lock <= 1'b1;
      end
      if (enter_dpd) lost_q <= 1'b1;
    end
  end

  assign mode      = mode_q;
  assign access_ok = mode_allows_access(mode_q);
  assign data_lost = lost_q;
endmodule

// File: rtl/lpm_seq_chk.sv
`timescale 1ns/1ps
module lpm_seq_chk
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              por_n,
  input logic              sleep_n,
  input logic [2:0]        mode,
  input logic              access_ok,
  input logic              refresh_en,
  input logic [ADDR_W-1:0] ref_lo,
  input logic [ADDR_W-1:0] ref_hi,
  input logic              qual_hit,
  input logic              cfg_acc,
  input logic              sw_lock
);
  assert_dpd_entry_qualified_R3: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_DPD && $past(mode) != M_DPD) |-> $past(qual_hit));

  assert_par_pin_exit_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_PAR && !sw_lock && sleep_n) |=> access_ok);

  assert_dpd_no_refresh_R5: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_DPD) |-> !refresh_en);

  assert_dpd_exit_init_R6: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_DPD && sleep_n) |=> (mode == M_INIT));

  assert_no_access_lowpower_R7: assert property (@(posedge clk) disable iff (!por_n)
    (mode == M_PAR || mode == M_DPD || mode == M_INIT) |-> !access_ok);

  assert_lock_blocks_pin_R8: assert property (@(posedge clk) disable iff (!por_n)
    (sw_lock && !cfg_acc && mode != M_PAR) |=> (mode != M_PAR && mode != M_DPD));

  assert_sw_never_dpd_R9: assert property (@(posedge clk) disable iff (!por_n)
    cfg_acc |=> (mode != M_DPD));

  assert_range_order_R10: assert property (@(posedge clk) disable iff (!por_n)
    refresh_en |-> (ref_lo <= ref_hi));
endmodule

bind lpm_seq lpm_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .sleep_n(sleep_n), .mode(mode), .access_ok(access_ok),
  .refresh_en(refresh_en), .ref_lo(ref_lo), .ref_hi(ref_hi), .qual_hit(qual_hit),
  .cfg_acc(cfg_acc), .sw_lock(sw_lock)
);

// File: tb/sim_lpm_seq.sv
`timescale 1ns/1ps
module sim_lpm_seq;
  localparam int AW = 8;
  localparam int Q  = 5;
  localparam int I  = 12;
  localparam int FULL = 1 << AW;

  logic clk = 1'b0;
  logic por_n, ce_n, sleep_n, cfg_we, cfg_sleep, cfg_top;
  logic [2:0] cfg_part;
  logic [2:0] mode;
  logic access_ok, refresh_en, data_lost;
  logic [AW-1:0] ref_lo, ref_hi;

  always #5 clk = ~clk;

  lpm_seq #(.ADDR_W(AW), .QUAL_CYC(Q), .INIT_CYC(I)) u0 (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .sleep_n(sleep_n), .cfg_we(cfg_we),
    .cfg_sleep(cfg_sleep), .cfg_top(cfg_top), .cfg_part(cfg_part), .mode(mode),
    .access_ok(access_ok), .refresh_en(refresh_en), .ref_lo(ref_lo), .ref_hi(ref_hi),
    .data_lost(data_lost)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model: 0 act, 1 stby, 2 partial, 3 deep, 4 init
  int m, lowc, ic, cs, ct, cp;
  bit sw, lost;

  always @(posedge clk) begin
    int nm, nrm;
    bit acc;
    if (!por_n) begin
      m = 1; lowc = 0; ic = 0; cs = 1; ct = 0; cp = 0; sw = 0; lost = 0;
    end else begin
      acc = cfg_we && !sleep_n && (m <= 2);
      nrm = (ce_n && sleep_n) ? 1 : 0;
      nm  = m;
      if (m == 3) begin
        if (sleep_n) begin nm = 4; ic = 0; end
      end else if (m == 4) begin
        if (ic == I - 1) nm = nrm; else ic++;
      end else if (acc) begin
        nm = cfg_sleep ? 2 : nrm;
      end else if (m == 2) begin
        if (!sw && sleep_n) nm = nrm;
      end else if (!sw && !sleep_n && lowc >= Q) begin
        nm = cs ? 2 : 3;
      end else begin
        nm = nrm;
      end
      if (acc) begin
        cs = cfg_sleep; ct = cfg_top; cp = cfg_part;
        if (cfg_sleep) sw = 1;
      end
      if (nm == 3) lost = 1;
      lowc = sleep_n ? 0 : lowc + 1;
      m = nm;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    int e_en, e_lo, e_hi, sz;
    if (por_n === 1'b1 && !finished) begin
      if (m == 3 || (m == 2 && cp >= 4)) begin
        e_en = 0; e_lo = 0; e_hi = 0;
      end else if (m == 2) begin
        sz = FULL / (1 << cp);
        e_lo = ct ? FULL - sz : 0;
        e_hi = e_lo + sz - 1;
        e_en = 1;
      end else begin
        e_en = 1; e_lo = 0; e_hi = FULL - 1;
      end
      chk("R3 model mode", int'(mode), m);
      chk("R7 model access", int'(access_ok), (m <= 1) ? 1 : 0);
      chk("R5 model refresh", int'(refresh_en), e_en);
      chk("R10 model lo", int'(ref_lo), e_lo);
      chk("R10 model hi", int'(ref_hi), e_hi);
      chk("R5 model lost", int'(data_lost), int'(lost));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input bit s, input bit t, input int p);
    sleep_n = 1'b0; cfg_we = 1'b1; cfg_sleep = s; cfg_top = t; cfg_part = p[2:0];
    tick(1);
    cfg_we = 1'b0; sleep_n = 1'b1;
  endtask

  task automatic summary();
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    por_n = 0; ce_n = 1; sleep_n = 1; cfg_we = 0; cfg_sleep = 0; cfg_top = 0; cfg_part = 0;
    tick(3);
    // R1 reset state
    chk("R1 mode", int'(mode), 1);
    chk("R1 access", int'(access_ok), 1);
    chk("R1 refresh", int'(refresh_en), 1);
    chk("R1 hi", int'(ref_hi), FULL - 1);
    chk("R1 lost", int'(data_lost), 0);
    por_n = 1;
    tick(1);
    // R2 active/standby
    ce_n = 0; tick(1); chk("R2 active", int'(mode), 0);
    ce_n = 1; tick(1); chk("R2 standby", int'(mode), 1);
    // R3 one sample short of qualifying
    sleep_n = 0; tick(Q); chk("R3 short low", int'(mode), 0);
    sleep_n = 1; tick(1); chk("R3 restart", int'(mode), 1);
    sleep_n = 0; tick(Q); chk("R3 not yet", int'(mode), 0);
    tick(1); chk("R4 partial entry", int'(mode), 2);
    chk("R7 partial no access", int'(access_ok), 0);
    chk("R10 default full lo", int'(ref_lo), 0);
    chk("R10 default full hi", int'(ref_hi), FULL - 1);
    sleep_n = 1; tick(1);
    chk("R4 partial exit", int'(mode), 1);
    chk("R4 access back", int'(access_ok), 1);
    // select deep power-down by register, no lock
    cfg_write(0, 0, 0);
    chk("R9 write bit0 normal", int'(mode), 0);
    tick(1);
    sleep_n = 0; tick(Q + 1);
    chk("R5 deep entry", int'(mode), 3);
    chk("R5 refresh off", int'(refresh_en), 0);
    chk("R5 lost set", int'(data_lost), 1);
    cfg_write(1, 0, 2);
    chk("R7 write ignored in deep", int'(mode), 3);
    tick(1);
    chk("R6 init entry", int'(mode), 4);
    chk("R7 init no access", int'(access_ok), 0);
    tick(I - 1);
    chk("R6 init still", int'(mode), 4);
    tick(1);
    chk("R6 init done", int'(mode), 1);
    chk("R5 lost sticky", int'(data_lost), 1);
    // the write during deep must not have set sleep-select
    sleep_n = 0; tick(Q + 1);
    chk("R7 cfg unchanged deep again", int'(mode), 3);
    sleep_n = 1; tick(1 + I);
    chk("R6 back to standby", int'(mode), 1);
    // R8 software partial with lock
    cfg_write(1, 0, 1);
    chk("R8 sw partial", int'(mode), 2);
    chk("R10 half bottom hi", int'(ref_hi), FULL / 2 - 1);
    tick(2);
    chk("R8 pin high keeps partial", int'(mode), 2);
    sleep_n = 0; ce_n = 0; tick(Q + 3);
    chk("R8 pin low keeps partial", int'(mode), 2);
    sleep_n = 1; ce_n = 1; tick(1);
    // R10 windows
    cfg_write(1, 1, 2);
    chk("R10 quarter top lo", int'(ref_lo), FULL - FULL / 4);
    chk("R10 quarter top hi", int'(ref_hi), FULL - 1);
    cfg_write(1, 0, 3);
    chk("R10 eighth bottom hi", int'(ref_hi), FULL / 8 - 1);
    cfg_write(1, 1, 3);
    chk("R10 eighth top lo", int'(ref_lo), FULL - FULL / 8);
    cfg_write(1, 0, 4);
    chk("R10 none refresh off", int'(refresh_en), 0);
    cfg_write(1, 1, 7);
    chk("R10 code7 none", int'(refresh_en), 0);
    cfg_write(1, 0, 0);
    chk("R10 full lo", int'(ref_lo), 0);
    // R9 leave partial by write of bit 0 while pin held low
    sleep_n = 0; cfg_we = 1; cfg_sleep = 0; cfg_part = 0; cfg_top = 0;
    tick(1); cfg_we = 0;
    chk("R9 write bit0 leaves partial", int'(mode), 0);
    tick(Q + 3);
    chk("R8 locked pin no deep", int'(mode), 0);
    chk("R8 locked refresh on", int'(refresh_en), 1);
    sleep_n = 1; tick(1);
    chk("R2 standby after", int'(mode), 1);
    tick(2);
    summary();
  end
endmodule